// File: doc/BRIEF.md
# Outstanding Request Table with Conflict Check

This block is the in-flight transaction tracker that a cache controller keeps beside a split-transaction coherence bus. Every request that wins the address bus carries a small tag; the block records the request in the slot whose index equals that tag. Every controller on the bus keeps an identical copy, so a tag names the same slot everywhere. Each slot remembers the block address, the kind of request, whether this cache issued it, whether this cache wants to pick up the data when it returns, and this cache's snoop verdict (shared or dirty) once that is known.

Lookups search by address across all slots at once. A processor access gets a combinational verdict in the same cycle: issue a new request, join the pending read, or stall until a clashing slot drains. A bus request that names a block already in flight is refused a slot; if this cache issued it, the block raises a withdraw signal so the request degrades to no action. A slot empties when the response carrying its tag appears, or at commit for writebacks and upgrades, which never see a response. The response lookup returns the stored snoop verdict and the sharing flags.

Top module: `orq_table`

## Requirements
- R1: After reset every slot is empty: a processor lookup reports no hit and the action ISSUE (code 0), and a response lookup reports no hit.
- R2: A bus request that does not conflict is recorded at the slot equal to its tag with its address and kind (kind codes: 0 read, 1 read-exclusive, 2 upgrade, 3 writeback); the originator flag is set only when this cache issued the request and is reported with the response.
- R3: The processor lookup compares its address against all valid slots in the same cycle and reports a hit flag and the index of the matching slot.
- R4: A processor read (kind 0) that matches a pending read not issued by this cache gets action GRAB (code 1) and, when presented with its valid strobe, sets that slot's want-to-grab flag; the response for that slot then reports the flag and asserts the shared-line output.
- R5: A processor access that matches a slot in any other combination gets action STALL (code 2) and sets no flag.
- R6: A processor access that matches no valid slot gets action ISSUE (code 0).
- R7: A bus request whose address matches a valid slot raises the conflict flag and index, is not recorded, and raises the withdraw output only when this cache issued it.
- R8: A snoop result written for a tag is stored in that slot and reported, shared and dirty, when the response for that tag is looked up.
- R9: A response whose tag names a valid slot reports a hit and frees the slot in the next cycle, so the tag can be reused for a new address.
- R10: A commit for a tag frees the slot only when it holds an upgrade or writeback; read and read-exclusive slots stay valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_valid | input | 1 | A request won the address bus this cycle |
| bus_req_tag | input | TAG_W | Tag given to that request |
| bus_req_addr | input | ADDR_W | Block address of the request |
| bus_req_kind | input | 2 | Request kind code |
| bus_req_mine | input | 1 | The request was issued by this cache |
| bus_conflict | output | 1 | Bus request address matches a valid slot |
| bus_conflict_idx | output | TAG_W | Index of that slot |
| bus_withdraw | output | 1 | This cache's request must degrade to no action |
| snp_valid | input | 1 | Local snoop verdict ready |
| snp_tag | input | TAG_W | Slot the verdict belongs to |
| snp_shared | input | 1 | Verdict: block held shared |
| snp_dirty | input | 1 | Verdict: block held dirty |
| rsp_valid | input | 1 | Tagged response seen on the data bus |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_hit | output | 1 | Response tag names a valid slot |
| rsp_shared | output | 1 | Stored shared verdict |
| rsp_dirty | output | 1 | Stored dirty verdict |
| rsp_grab | output | 1 | This cache takes the data |
| rsp_orig | output | 1 | This cache issued the request |
| rsp_share_line | output | 1 | Drive the shared line (non-original grabber) |
| commit_valid | input | 1 | A request passed its commit point |
| commit_tag | input | TAG_W | Tag of the committed request |
| cpu_valid | input | 1 | Processor access is acted on this cycle |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_kind | input | 2 | Kind the processor would issue |
| cpu_hit | output | 1 | Processor address matches a valid slot |
| cpu_idx | output | TAG_W | Index of the matching slot |
| cpu_action | output | 2 | 0 issue, 1 grab, 2 stall |

## Verification
The bench builds the table with its defaults, eight slots and 32-bit addresses, so tags 0 through 7 are all reachable and the highest tag is exercised on reuse. With three-bit tags, conflict, grab and stall cases can sit in distinct slots at once, which shows the associative search returns the right index rather than the first valid slot.

// File: rtl/orq_pkg.sv
package orq_pkg;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_RDX = 2'd1,
    KIND_UPG = 2'd2,
    KIND_WB  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ACT_ISSUE = 2'd0,
    ACT_GRAB  = 2'd1,
    ACT_STALL = 2'd2
  } cpu_act_e;

  // Kinds with no data response retire at commit.
  function automatic logic kind_dataless(input logic [1:0] k);
    return (k == KIND_UPG) || (k == KIND_WB);
  endfunction

  // Verdict for a processor access that hit a pending slot.
  function automatic logic [1:0] hit_verdict(input logic [1:0] cpu_k,
                                             input logic [1:0] slot_k,
                                             input logic       slot_orig);
    if (cpu_k == KIND_RD && slot_k == KIND_RD && !slot_orig)
      return ACT_GRAB;
    return ACT_STALL;
  endfunction

endpackage

// File: rtl/orq_entry.sv
module orq_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_kind,
  input  logic              alloc_orig,
  input  logic              clear,
  input  logic              set_grab,
  input  logic              set_snoop,
  input  logic              snoop_shared,
  input  logic              snoop_dirty,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        kind,
  output logic              orig,
  output logic              grab,
  output logic              known,
  output logic              shared,
  output logic              dirty
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr   <= '0;
      kind   <= '0;
      orig   <= 1'b0;
      grab   <= 1'b0;
      known  <= 1'b0;
      shared <= 1'b0;
      dirty  <= 1'b0;
    end else if (alloc) begin
      valid  <= 1'b1;
      addr   <= alloc_addr;
      kind   <= alloc_kind;
      orig   <= alloc_orig;
      grab   <= 1'b0;
      known  <= 1'b0;
      shared <= 1'b0;
      dirty  <= 1'b0;
    end else if (clear) begin
      valid <= 1'b0;
      grab  <= 1'b0;
      known <= 1'b0;
    end else begin
      if (set_grab && valid) grab <= 1'b1;
      if (set_snoop && valid) begin
        known  <= 1'b1;
        shared <= snoop_shared;
        dirty  <= snoop_dirty;
      end
    end
  end

  AST_GRAB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    grab |-> valid); // R4

endmodule

// File: rtl/orq_match.sv
module orq_match #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int TAG_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0]             vld,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addrs,
  input  logic [ADDR_W-1:0]                  key,
  output logic                               hit,
  output logic [TAG_W-1:0]                   idx,
  output logic [NUM_ENTRIES-1:0]             hits
);

  function automatic logic [TAG_W-1:0] lowest_set(input logic [NUM_ENTRIES-1:0] v);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = TAG_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hits[g] = vld[g] && (addrs[g] == key);
  end

  assign hit = |hits;
  assign idx = lowest_set(hits);

endmodule

// File: rtl/orq_table.sv
module orq_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int TAG_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_valid,
  input  logic [TAG_W-1:0]  bus_req_tag,
  input  logic [ADDR_W-1:0] bus_req_addr,
  input  logic [1:0]        bus_req_kind,
  input  logic              bus_req_mine,
  output logic              bus_conflict,
  output logic [TAG_W-1:0]  bus_conflict_idx,
  output logic              bus_withdraw,
  input  logic              snp_valid,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              snp_shared,
  input  logic              snp_dirty,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_hit,
  output logic              rsp_shared,
  output logic              rsp_dirty,
  output logic              rsp_grab,
  output logic              rsp_orig,
  output logic              rsp_share_line,
  input  logic              commit_valid,
  input  logic [TAG_W-1:0]  commit_tag,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_kind,
  output logic              cpu_hit,
  output logic [TAG_W-1:0]  cpu_idx,
  output logic [1:0]        cpu_action
);
  import orq_pkg::*;

  logic [NUM_ENTRIES-1:0]             ent_valid, ent_orig, ent_grab;
  logic [NUM_ENTRIES-1:0]             ent_known, ent_shared, ent_dirty;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [NUM_ENTRIES-1:0][1:0]        ent_kind;
  logic [NUM_ENTRIES-1:0]             cpu_hits, bus_hits;

  // Named internal events used by the assertions.
  logic alloc_go;
  logic grab_go;

  orq_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_cpu_match (
    .vld(ent_valid), .addrs(ent_addr), .key(cpu_addr),
    .hit(cpu_hit), .idx(cpu_idx), .hits(cpu_hits)
  );

  orq_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_bus_match (
    .vld(ent_valid), .addrs(ent_addr), .key(bus_req_addr),
    .hit(bus_conflict), .idx(bus_conflict_idx), .hits(bus_hits)
  );

  always_comb begin
    if (!cpu_hit) cpu_action = ACT_ISSUE;
    else          cpu_action = hit_verdict(cpu_kind, ent_kind[cpu_idx], ent_orig[cpu_idx]);
  end

  assign alloc_go     = bus_req_valid && !bus_conflict;
  assign bus_withdraw = bus_req_valid && bus_conflict && bus_req_mine;
  assign grab_go      = cpu_valid && (cpu_action == ACT_GRAB);

  assign rsp_hit        = rsp_valid && ent_valid[rsp_tag];
  assign rsp_shared     = rsp_hit && ent_known[rsp_tag] && ent_shared[rsp_tag];
  assign rsp_dirty      = rsp_hit && ent_known[rsp_tag] && ent_dirty[rsp_tag];
  assign rsp_grab       = rsp_hit && ent_grab[rsp_tag];
  assign rsp_orig       = rsp_hit && ent_orig[rsp_tag];
  assign rsp_share_line = rsp_grab && !rsp_orig;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    logic sel_alloc, sel_clear, sel_grab, sel_snoop;
    assign sel_alloc = alloc_go && (bus_req_tag == TAG_W'(g));
    assign sel_clear = (rsp_valid && rsp_tag == TAG_W'(g)) ||
                       (commit_valid && commit_tag == TAG_W'(g) && kind_dataless(ent_kind[g]));
    assign sel_grab  = grab_go && (cpu_idx == TAG_W'(g));
    assign sel_snoop = snp_valid && (snp_tag == TAG_W'(g));

    orq_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc(sel_alloc), .alloc_addr(bus_req_addr), .alloc_kind(bus_req_kind),
      .alloc_orig(bus_req_mine), .clear(sel_clear), .set_grab(sel_grab),
      .set_snoop(sel_snoop), .snoop_shared(snp_shared), .snoop_dirty(snp_dirty),
      .valid(ent_valid[g]), .addr(ent_addr[g]), .kind(ent_kind[g]),
      .orig(ent_orig[g]), .grab(ent_grab[g]), .known(ent_known[g]),
      .shared(ent_shared[g]), .dirty(ent_dirty[g])
    );
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_hits) && $onehot0(bus_hits)); // R3

  AST_GRAB_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    grab_go && !rsp_valid && !bus_req_valid |=> ent_grab[$past(cpu_idx)]); // R4

  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_conflict && !ent_valid[bus_req_tag]
    |=> !ent_valid[$past(bus_req_tag)]); // R7

  AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !bus_req_valid |=> !ent_valid[$past(rsp_tag)]); // R9

  AST_COMMIT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && ent_valid[commit_tag] && !kind_dataless(ent_kind[commit_tag]) &&
    !rsp_valid |=> ent_valid[$past(commit_tag)]); // R10

endmodule

// File: tb/orq_table_tb.sv
module orq_table_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          bus_req_valid, bus_req_mine, snp_valid, snp_shared, snp_dirty;
  logic [TW-1:0] bus_req_tag, snp_tag, rsp_tag, commit_tag;
  logic [AW-1:0] bus_req_addr, cpu_addr;
  logic [1:0]    bus_req_kind, cpu_kind;
  logic          rsp_valid, commit_valid, cpu_valid;
  logic          bus_conflict, bus_withdraw, rsp_hit, rsp_shared, rsp_dirty;
  logic          rsp_grab, rsp_orig, rsp_share_line, cpu_hit;
  logic [TW-1:0] bus_conflict_idx, cpu_idx;
  logic [1:0]    cpu_action;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  orq_table #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut_i (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_req_valid = 0; bus_req_tag = 0; bus_req_addr = 0; bus_req_kind = 0; bus_req_mine = 0;
    snp_valid = 0; snp_tag = 0; snp_shared = 0; snp_dirty = 0;
    rsp_valid = 0; rsp_tag = 0; commit_valid = 0; commit_tag = 0;
    cpu_valid = 0; cpu_addr = 0; cpu_kind = 0;
  endtask

  task automatic edge_step();
    @(posedge clk); #1; idle();
  endtask

  task automatic bus_put(int tag, int addr, int kind, bit mine);
    bus_req_valid = 1; bus_req_tag = TW'(tag); bus_req_addr = AW'(addr);
    bus_req_kind = 2'(kind); bus_req_mine = mine;
    edge_step();
  endtask

  task automatic look(string req, int addr, int kind, bit act_on,
                      bit e_hit, int e_idx, int e_act);
    cpu_valid = act_on; cpu_addr = AW'(addr); cpu_kind = 2'(kind); #1;
    chk(req, "cpu_hit", cpu_hit, e_hit);
    if (e_hit) chk(req, "cpu_idx", cpu_idx, e_idx);
    chk(req, "cpu_action", cpu_action, e_act);
    edge_step();
  endtask

  task automatic test_reset();
    look("R1", 'h100, 0, 0, 0, 0, 0);
    rsp_valid = 1; rsp_tag = 3; #1;
    chk("R1", "rsp_hit", rsp_hit, 0);
    edge_step();
  endtask

  task automatic test_alloc_and_lookup();
    bus_put(3, 'h100, 0, 0);
    bus_put(5, 'h200, 1, 1);
    look("R3", 'h100, 1, 1, 1, 3, 2);      // R5 readx vs pending read
    look("R4", 'h100, 0, 1, 1, 3, 1);      // grab, sets flag
    look("R5", 'h200, 0, 1, 1, 5, 2);      // read vs pending readx
    look("R6", 'h300, 0, 1, 0, 0, 0);
  endtask

  task automatic test_response();
    snp_valid = 1; snp_tag = 3; snp_shared = 1; snp_dirty = 0;
    edge_step();
    rsp_valid = 1; rsp_tag = 3; #1;
    chk("R9", "rsp_hit", rsp_hit, 1);
    chk("R8", "rsp_shared", rsp_shared, 1);
    chk("R8", "rsp_dirty", rsp_dirty, 0);
    chk("R4", "rsp_grab", rsp_grab, 1);
    chk("R2", "rsp_orig", rsp_orig, 0);
    chk("R4", "rsp_share_line", rsp_share_line, 1);
    edge_step();
    look("R9", 'h100, 0, 0, 0, 0, 0);
    snp_valid = 1; snp_tag = 5; snp_shared = 0; snp_dirty = 1;
    edge_step();
    rsp_valid = 1; rsp_tag = 5; #1;
    chk("R2", "rsp_orig", rsp_orig, 1);
    chk("R8", "rsp_dirty", rsp_dirty, 1);
    chk("R4", "rsp_share_line", rsp_share_line, 0);
    edge_step();
  endtask

  task automatic test_conflict();
    bus_put(1, 'h400, 3, 0);
    bus_req_valid = 1; bus_req_tag = 2; bus_req_addr = 'h400; bus_req_kind = 1; bus_req_mine = 1; #1;
    chk("R7", "bus_conflict", bus_conflict, 1);
    chk("R7", "bus_conflict_idx", bus_conflict_idx, 1);
    chk("R7", "bus_withdraw", bus_withdraw, 1);
    edge_step();
    bus_req_valid = 1; bus_req_tag = 6; bus_req_addr = 'h400; bus_req_kind = 0; bus_req_mine = 0; #1;
    chk("R7", "bus_withdraw foreign", bus_withdraw, 0);
    edge_step();
    rsp_valid = 1; rsp_tag = 2; #1;
    chk("R7", "rsp_hit tag2", rsp_hit, 0);
    rsp_tag = 6; #1;
    chk("R7", "rsp_hit tag6", rsp_hit, 0);
    rsp_valid = 0; #1;
    look("R7", 'h400, 0, 0, 1, 1, 2);
  endtask

  task automatic test_commit();
    commit_valid = 1; commit_tag = 1; edge_step();
    look("R10", 'h400, 0, 0, 0, 0, 0);
    bus_put(4, 'h500, 0, 1);
    commit_valid = 1; commit_tag = 4; edge_step();
    look("R10", 'h500, 1, 0, 1, 4, 2);
    bus_put(6, 'h600, 2, 1);
    commit_valid = 1; commit_tag = 6; edge_step();
    look("R10", 'h600, 0, 0, 0, 0, 0);
  endtask

  task automatic test_reuse();
    bus_put(3, 'h700, 1, 0);
    bus_put(7, 'h800, 0, 1);
    look("R9", 'h700, 0, 0, 1, 3, 2);
    look("R4", 'h800, 0, 1, 1, 7, 2);      // own read: stall, not grab
    rsp_valid = 1; rsp_tag = 7; #1;
    chk("R4", "rsp_grab own", rsp_grab, 0);
    edge_step();
    bus_put(7, 'h900, 0, 0);
    look("R9", 'h900, 0, 0, 1, 7, 1);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    test_reset();
    test_alloc_and_lookup();
    test_response();
    test_conflict();
    test_commit();
    test_reuse();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule